// File: doc/BRIEF.md
# DMA FIFO Residual Byte Tracker

This block is a byte-wide DMA FIFO that can always tell how many bytes it still holds, using two free-running counters instead of a direct fill level. An offset counter advances for every byte written into the FIFO. A transfer counter advances for every byte that leaves the FIFO toward the output path. The residue is the difference of their low bits, masked to the width of the active depth mode. A single configuration bit picks one of two depths: 88 bytes with a 7-bit offset, or 536 bytes with a 10-bit offset.

Bytes leave the FIFO into a 16-bit, two-lane output data latch. From there they pass into a 16-bit output data register that a downstream sink consumes one lane at a time. Each lane of both stages has its own full flag, so software can find bytes stranded in the staging path. One example is the single byte that remains after a move with an odd byte count. The flags appear in two status bytes, one for the low lane and one for the high lane. A FIFO clear, or any change of the depth mode, empties everything.

Top module: `dma_resid_fifo`

## Requirements
- R1: With `deep_mode` low the FIFO holds at most 88 bytes. With it high it holds at most 536. A push offered while the FIFO is at that limit is dropped, and `residual` stays at the limit.
- R2: `{ofs_hi, ofs_lo}` is the offset counter. It rises by one per accepted push and wraps to 0 after 127 in the 88-byte mode, or after 1023 in the 536-byte mode.
- R3: `xfer_count` rises by one for each byte that moves from the FIFO into the output latch, and wraps at its full width.
- R4: `residual` equals the number of bytes held in the FIFO. It also equals (offset − low bits of `xfer_count`) masked with 0x7F in the 88-byte mode or with 0x3FF in the 536-byte mode.
- R5: Bytes enter the latch alternately, low lane (bits 7:0) first, then high lane (bits 15:8). A byte moves only when the lane it targets is empty, and it is taken in FIFO order.
- R6: A latch lane passes its byte to the matching output register lane only when that register lane is empty. The source flag clears and the destination flag sets on the same edge.
- R7: `stat_lo` bit 5 is the low latch lane full flag and bit 6 is the low output register lane full flag. `stat_hi` carries the same two flags for the high lane at the same bit positions. All other status bits read 0.
- R8: A byte left in a latch lane keeps that lane's full flag set until it moves on into the output register.
- R9: `take_lo` or `take_hi` empties the matching output register lane. `out_word` lanes that are flagged full carry the bytes in FIFO order.
- R10: `fifo_clr`, or a change of `deep_mode`, clears the offset and transfer counters, the FIFO and all four lane flags on the next edge. A push offered in that cycle is dropped.
- R11: Reset clears every counter and flag. All status outputs come from registers and change at the clock edge that samples the event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| deep_mode | input | 1 | Depth select: 0 = 88 bytes, 1 = 536 bytes |
| fifo_clr | input | 1 | Synchronous flush of FIFO, counters and flags |
| push_en | input | 1 | Offer one byte to the FIFO |
| push_byte | input | 8 | Byte offered |
| take_lo | input | 1 | Sink consumes the low output register lane |
| take_hi | input | 1 | Sink consumes the high output register lane |
| out_word | output | 16 | Output data register contents |
| ofs_hi | output | 2 | Offset counter bits 9:8 |
| ofs_lo | output | 8 | Offset counter bits 7:0 |
| xfer_count | output | XW | Transfer byte counter |
| residual | output | 10 | Bytes remaining in the FIFO |
| stat_lo | output | 8 | Low lane status: bit 5 latch full, bit 6 register full |
| stat_hi | output | 8 | High lane status: bit 5 latch full, bit 6 register full |

## Verification
On every cycle the assertions check four things. Residue stays within the active depth. Reserved status bits stay zero. The offset steps by at most one between flushes. Flags that nothing may clear do not drop: the output register flag without a take, and the latch flag while the register lane is blocked. Byte ordering across the two lanes, the exact residue after overflow attempts, and correct wraparound at 128 and 1024 can only be shown by the bench. The same holds for the effect of a depth change on data in flight. The bench shows these by running a queue-based model in lockstep through fill, overflow, streaming, odd-count stranding, clears and mode switches.

// File: rtl/drf_pkg.sv
package drf_pkg;

    localparam int OFS_W   = 10;
    localparam int LANES   = 2;

    typedef struct packed {
        logic       full;
        logic [7:0] data;
    } lane_t;

    function automatic logic [OFS_W-1:0] ofs_mask(input logic deep);
        return deep ? 10'h3FF : 10'h07F;
    endfunction

endpackage

// File: rtl/drf_store.sv
module drf_store #(
    parameter int DEPTH = 536,
    parameter int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [7:0]       wr_data,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [7:0]       rd_data
);

    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_idx] <= wr_data;
        end
    end

    assign rd_data = mem[rd_idx];

endmodule

// File: rtl/drf_count.sv
module drf_count
    import drf_pkg::*;
#(
    parameter int DEPTH_S = 88,
    parameter int DEPTH_L = 536,
    parameter int XW      = 16,
    parameter int IDX_W   = $clog2(DEPTH_L)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             deep_mode,
    input  logic             fifo_clr,
    input  logic             push_en,
    input  logic             pop,
    output logic             flush,
    output logic             mode_q,
    output logic             nonempty,
    output logic             wr_en,
    output logic [IDX_W-1:0] wr_idx,
    output logic [IDX_W-1:0] rd_idx,
    output logic [OFS_W-1:0] ofs,
    output logic [XW-1:0]    xfer,
    output logic [OFS_W-1:0] residual
);

    localparam logic [OFS_W-1:0] LIM_S  = OFS_W'(DEPTH_S);
    localparam logic [OFS_W-1:0] LIM_L  = OFS_W'(DEPTH_L);
    localparam logic [IDX_W-1:0] LAST_S = IDX_W'(DEPTH_S - 1);
    localparam logic [IDX_W-1:0] LAST_L = IDX_W'(DEPTH_L - 1);

    typedef struct packed {
        logic             mode;
        logic [OFS_W-1:0] ofs;
        logic [XW-1:0]    xfer;
        logic [IDX_W-1:0] wr;
        logic [IDX_W-1:0] rd;
        logic [OFS_W-1:0] resid;
    } cnt_st_t;

    cnt_st_t cnt_q, cnt_d;

    logic [OFS_W-1:0] lim;
    logic [IDX_W-1:0] last;
    logic [OFS_W-1:0] mask_d;
    logic             full;

    always_comb begin
        flush    = fifo_clr | (deep_mode != cnt_q.mode);
        lim      = cnt_q.mode ? LIM_L  : LIM_S;
        last     = cnt_q.mode ? LAST_L : LAST_S;
        nonempty = (cnt_q.resid != '0);
        full     = (cnt_q.resid >= lim);
        wr_en    = push_en & ~full & ~flush;

        cnt_d      = cnt_q;
        cnt_d.mode = deep_mode;
        mask_d     = ofs_mask(deep_mode);

        if (flush) begin
            cnt_d.ofs   = '0;
            cnt_d.xfer  = '0;
            cnt_d.wr    = '0;
            cnt_d.rd    = '0;
            cnt_d.resid = '0;
        end else begin
            if (wr_en) begin
                cnt_d.ofs = (cnt_q.ofs + 1'b1) & mask_d;
                cnt_d.wr  = (cnt_q.wr == last) ? '0 : cnt_q.wr + 1'b1;
            end
            if (pop) begin
                cnt_d.xfer = cnt_q.xfer + 1'b1;
                cnt_d.rd   = (cnt_q.rd == last) ? '0 : cnt_q.rd + 1'b1;
            end
            cnt_d.resid = (cnt_d.ofs - cnt_d.xfer[OFS_W-1:0]) & mask_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign mode_q   = cnt_q.mode;
    assign wr_idx   = cnt_q.wr;
    assign rd_idx   = cnt_q.rd;
    assign ofs      = cnt_q.ofs;
    assign xfer     = cnt_q.xfer;
    assign residual = cnt_q.resid;

endmodule

// File: rtl/drf_lanes.sv
module drf_lanes
    import drf_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             nonempty,
    input  logic [7:0]       rd_data,
    input  logic             take_lo,
    input  logic             take_hi,
    output logic             pop,
    output logic [LANES-1:0] lat_full,
    output logic [LANES-1:0] reg_full,
    output logic [15:0]      out_word
);

    typedef struct packed {
        logic                ptr;
        lane_t [LANES-1:0]   lat;
        lane_t [LANES-1:0]   orr;
    } lane_st_t;

    lane_st_t ln_q, ln_d;

    logic [LANES-1:0] take;
    logic [LANES-1:0] mv;

    assign take = {take_hi, take_lo};

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign mv[g]       = ln_q.lat[g].full & ~ln_q.orr[g].full;
        assign lat_full[g] = ln_q.lat[g].full;
        assign reg_full[g] = ln_q.orr[g].full;
        assign out_word[8*g +: 8] = ln_q.orr[g].data;
    end

    always_comb begin
        pop  = nonempty & ~ln_q.lat[ln_q.ptr].full & ~flush;
        ln_d = ln_q;
        if (flush) begin
            ln_d.ptr = 1'b0;
            for (int i = 0; i < LANES; i++) begin
                ln_d.lat[i].full = 1'b0;
                ln_d.orr[i].full = 1'b0;
            end
        end else begin
            for (int i = 0; i < LANES; i++) begin
                ln_d.orr[i].full = (ln_q.orr[i].full & ~take[i]) | mv[i];
                if (mv[i]) begin
                    ln_d.orr[i].data = ln_q.lat[i].data;
                end
                ln_d.lat[i].full = ln_q.lat[i].full & ~mv[i];
            end
            if (pop) begin
                ln_d.lat[ln_q.ptr].full = 1'b1;
                ln_d.lat[ln_q.ptr].data = rd_data;
                ln_d.ptr                = ~ln_q.ptr;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ln_q <= '0;
        end else begin
            ln_q <= ln_d;
        end
    end

endmodule

// File: rtl/dma_resid_fifo.sv
module dma_resid_fifo
    import drf_pkg::*;
#(
    parameter int DEPTH_S = 88,
    parameter int DEPTH_L = 536,
    parameter int XW      = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          deep_mode,
    input  logic          fifo_clr,
    input  logic          push_en,
    input  logic [7:0]    push_byte,
    input  logic          take_lo,
    input  logic          take_hi,
    output logic [15:0]   out_word,
    output logic [1:0]    ofs_hi,
    output logic [7:0]    ofs_lo,
    output logic [XW-1:0] xfer_count,
    output logic [9:0]    residual,
    output logic [7:0]    stat_lo,
    output logic [7:0]    stat_hi
);

    localparam int IDX_W = $clog2(DEPTH_L);

    logic             flush_w;
    logic             mode_q_w;
    logic             nonempty_w;
    logic             wr_en_w;
    logic             pop_w;
    logic [IDX_W-1:0] wr_idx_w;
    logic [IDX_W-1:0] rd_idx_w;
    logic [7:0]       rd_data_w;
    logic [OFS_W-1:0] ofs_w;
    logic [LANES-1:0] lat_full_w;
    logic [LANES-1:0] reg_full_w;

    drf_count #(
        .DEPTH_S (DEPTH_S),
        .DEPTH_L (DEPTH_L),
        .XW      (XW),
        .IDX_W   (IDX_W)
    ) u_count (
        .clk      (clk),
        .rst_n    (rst_n),
        .deep_mode(deep_mode),
        .fifo_clr (fifo_clr),
        .push_en  (push_en),
        .pop      (pop_w),
        .flush    (flush_w),
        .mode_q   (mode_q_w),
        .nonempty (nonempty_w),
        .wr_en    (wr_en_w),
        .wr_idx   (wr_idx_w),
        .rd_idx   (rd_idx_w),
        .ofs      (ofs_w),
        .xfer     (xfer_count),
        .residual (residual)
    );

    drf_store #(
        .DEPTH (DEPTH_L),
        .IDX_W (IDX_W)
    ) u_store (
        .clk     (clk),
        .wr_en   (wr_en_w),
        .wr_idx  (wr_idx_w),
        .wr_data (push_byte),
        .rd_idx  (rd_idx_w),
        .rd_data (rd_data_w)
    );

    drf_lanes u_lanes (
        .clk      (clk),
        .rst_n    (rst_n),
        .flush    (flush_w),
        .nonempty (nonempty_w),
        .rd_data  (rd_data_w),
        .take_lo  (take_lo),
        .take_hi  (take_hi),
        .pop      (pop_w),
        .lat_full (lat_full_w),
        .reg_full (reg_full_w),
        .out_word (out_word)
    );

    assign ofs_hi  = ofs_w[9:8];
    assign ofs_lo  = ofs_w[7:0];
    assign stat_lo = {1'b0, reg_full_w[0], lat_full_w[0], 5'b0};
    assign stat_hi = {1'b0, reg_full_w[1], lat_full_w[1], 5'b0};

endmodule

// File: rtl/drf_checker.sv
module drf_checker #(
    parameter int DEPTH_S = 88,
    parameter int DEPTH_L = 536
) (
    input logic       clk,
    input logic       rst_n,
    input logic       flush,
    input logic       mode_q,
    input logic       take_lo,
    input logic [9:0] residual,
    input logic [9:0] ofs,
    input logic [7:0] stat_lo,
    input logic [7:0] stat_hi
);

    localparam logic [9:0] LIM_S = 10'(DEPTH_S);
    localparam logic [9:0] LIM_L = 10'(DEPTH_L);

    p_resid_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
        residual <= (mode_q ? LIM_L : LIM_S));

    p_ofs_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !flush |=> (((ofs - $past(ofs)) & (mode_q ? 10'h3FF : 10'h07F)) <= 10'd1));

    p_reserved_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((stat_lo & 8'h9F) == 8'h00) && ((stat_hi & 8'h9F) == 8'h00));

    p_latch_kept_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_lo[5] && stat_lo[6] && !take_lo && !flush) |=> stat_lo[5]);

    p_reg_kept_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_lo[6] && !take_lo && !flush) |=> stat_lo[6]);

    p_flush_empty_r10: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (residual == 10'd0) && (ofs == 10'd0)
                  && (stat_lo == 8'h00) && (stat_hi == 8'h00));

endmodule

bind dma_resid_fifo drf_checker #(
    .DEPTH_S (DEPTH_S),
    .DEPTH_L (DEPTH_L)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .flush    (flush_w),
    .mode_q   (mode_q_w),
    .take_lo  (take_lo),
    .residual (residual),
    .ofs      ({ofs_hi, ofs_lo}),
    .stat_lo  (stat_lo),
    .stat_hi  (stat_hi)
);

// File: tb/sim_dma_resid_fifo.sv
`timescale 1ns/1ps
module sim_dma_resid_fifo;

    localparam int XW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          deep_mode = 1'b0;
    logic          fifo_clr = 1'b0;
    logic          push_en = 1'b0;
    logic [7:0]    push_byte = 8'h00;
    logic          take_lo = 1'b0;
    logic          take_hi = 1'b0;
    logic [15:0]   out_word;
    logic [1:0]    ofs_hi;
    logic [7:0]    ofs_lo;
    logic [XW-1:0] xfer_count;
    logic [9:0]    residual;
    logic [7:0]    stat_lo;
    logic [7:0]    stat_hi;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    // behavioural model state
    byte unsigned mq[$];
    int  m_ofs = 0;
    int  m_xfer = 0;
    bit  m_mode = 1'b0;
    bit  m_ptr = 1'b0;
    bit  lf[2];
    bit  rf[2];
    byte unsigned ld[2];
    byte unsigned rd[2];

    always #2 clk = ~clk;

    dma_resid_fifo #(.XW(XW)) u0 (
        .clk(clk), .rst_n(rst_n), .deep_mode(deep_mode), .fifo_clr(fifo_clr),
        .push_en(push_en), .push_byte(push_byte), .take_lo(take_lo), .take_hi(take_hi),
        .out_word(out_word), .ofs_hi(ofs_hi), .ofs_lo(ofs_lo), .xfer_count(xfer_count),
        .residual(residual), .stat_lo(stat_lo), .stat_hi(stat_hi)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int mmask();
        return m_mode ? 1023 : 127;
    endfunction

    function automatic int mdepth();
        return m_mode ? 536 : 88;
    endfunction

    task automatic step();
        bit fl;
        bit mv[2];
        bit pop;
        bit psh;
        bit tk[2];
        fl = fifo_clr || (deep_mode != m_mode);
        m_mode = deep_mode;
        tk[0] = take_lo;
        tk[1] = take_hi;
        if (fl) begin
            mq.delete();
            m_ofs = 0;
            m_xfer = 0;
            m_ptr = 1'b0;
            for (int i = 0; i < 2; i++) begin
                lf[i] = 1'b0;
                rf[i] = 1'b0;
            end
        end else begin
            pop = (mq.size() > 0) && !lf[m_ptr];
            psh = push_en && (mq.size() < mdepth());
            for (int i = 0; i < 2; i++) begin
                mv[i] = lf[i] && !rf[i];
                rf[i] = (rf[i] && !tk[i]) || mv[i];
                if (mv[i]) rd[i] = ld[i];
                if (mv[i]) lf[i] = 1'b0;
            end
            if (pop) begin
                lf[m_ptr] = 1'b1;
                ld[m_ptr] = mq.pop_front();
                m_ptr = ~m_ptr;
                m_xfer = m_xfer + 1;
            end
            if (psh) begin
                mq.push_back(push_byte);
                m_ofs = (m_ofs + 1) & mmask();
            end
        end
    endtask

    task automatic compare();
        int ofs_v;
        ofs_v = {ofs_hi, ofs_lo};
        chk(ofs_v == m_ofs, "R2", "offset", ofs_v, m_ofs);
        chk(xfer_count == XW'(m_xfer), "R3", "xfer_count", xfer_count, m_xfer & 16'hFFFF);
        chk(residual == mq.size(), "R4", "residual vs held bytes", residual, mq.size());
        chk(int'((ofs_v - xfer_count[9:0]) & mmask()) == int'(residual), "R4",
            "residual vs counter difference", residual, (ofs_v - xfer_count[9:0]) & mmask());
        chk(stat_lo == {1'b0, rf[0], lf[0], 5'b0}, "R7", "stat_lo", stat_lo,
            {1'b0, rf[0], lf[0], 5'b0});
        chk(stat_hi == {1'b0, rf[1], lf[1], 5'b0}, "R7", "stat_hi", stat_hi,
            {1'b0, rf[1], lf[1], 5'b0});
        if (rf[0]) chk(out_word[7:0] == rd[0], "R9", "low lane data", out_word[7:0], rd[0]);
        if (rf[1]) chk(out_word[15:8] == rd[1], "R9", "high lane data", out_word[15:8], rd[1]);
    endtask

    // inputs are already set at a negedge; advance one clock
    task automatic cyc();
        step();
        @(posedge clk);
        @(negedge clk);
        compare();
    endtask

    task automatic run(input int n, input int p_push, input int p_take);
        for (int k = 0; k < n; k++) begin
            push_en   = ($urandom_range(99) < p_push);
            push_byte = 8'($urandom);
            take_lo   = ($urandom_range(99) < p_take);
            take_hi   = ($urandom_range(99) < p_take);
            cyc();
        end
        push_en = 1'b0;
        take_lo = 1'b0;
        take_hi = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) cyc();
    endtask

    initial begin
        // R11: reset state
        repeat (3) @(negedge clk);
        chk(residual == 0 && xfer_count == 0 && {ofs_hi, ofs_lo} == 0, "R11",
            "counters in reset", residual, 0);
        chk(stat_lo == 0 && stat_hi == 0, "R11", "flags in reset", {stat_lo, stat_hi}, 0);
        rst_n = 1'b1;
        idle(2);

        // R1: fill the 88-byte FIFO and keep offering
        run(120, 100, 0);
        chk(residual == 10'd88, "R1", "small mode limit", residual, 88);
        // R5/R6: four bytes staged in latch and register
        chk(stat_lo[6] && stat_hi[6] && stat_lo[5] && stat_hi[5], "R6",
            "both stages full", {stat_lo, stat_hi}, 16'h6060);

        // streaming, offset wraps past 127 (R2)
        run(400, 60, 55);
        run(40, 0, 100);

        // R10: clear with a push in the same cycle
        fifo_clr = 1'b1; push_en = 1'b1; push_byte = 8'hA5;
        cyc();
        fifo_clr = 1'b0; push_en = 1'b0;
        chk(residual == 0 && {ofs_hi, ofs_lo} == 0, "R10", "clear drops push", residual, 0);

        // R8: odd count leaves one byte stranded in the low latch lane
        for (int k = 0; k < 3; k++) begin
            push_en = 1'b1; push_byte = 8'(8'h30 + k);
            cyc();
        end
        push_en = 1'b0;
        idle(6);
        chk(stat_lo[5] == 1'b1, "R8", "stranded low latch byte", stat_lo[5], 1);
        chk(out_word == 16'h3130, "R5", "lane order", out_word, 16'h3130);
        take_lo = 1'b1; cyc(); take_lo = 1'b0;
        idle(2);
        chk(out_word[7:0] == 8'h32 && stat_lo[5] == 1'b0, "R9", "stranded byte forwarded",
            out_word[7:0], 8'h32);
        take_lo = 1'b1; take_hi = 1'b1; cyc(); take_lo = 1'b0; take_hi = 1'b0;

        // R10: mode change with data in flight, then deep mode fill
        run(30, 100, 0);
        deep_mode = 1'b1;
        cyc();
        chk(residual == 0 && stat_lo == 0 && stat_hi == 0, "R10", "mode change flush",
            residual, 0);
        run(700, 100, 0);
        chk(residual == 10'd536, "R1", "deep mode limit", residual, 536);
        run(3000, 55, 60);
        run(80, 0, 100);

        // back to small mode
        deep_mode = 1'b0;
        run(300, 60, 50);

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        #(4ns * 150000);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

endmodule